// File: doc/BRIEF.md
# Serial Flash Instruction Front-End

This block is the slave-side command decoder of a serial NOR flash. It runs on a fast local clock and samples the serial clock, chip-select and data-in lines as synchronous inputs. While chip-select is low it shifts in an 8-bit opcode on each rising serial-clock edge. It then collects the address, dummy and data bytes that the opcode calls for. The back end of the memory gets one-cycle command strobes, together with a 24-bit address and up to two bytes of write data.

Read-type instructions stream bytes on the serial output for as long as chip-select stays low. These are memory read, fast read, status read, the manufacturer/device identifier read and the three-byte identifier read. Output bits change on the falling serial-clock edge. Write-class instructions take effect only when chip-select rises on a byte boundary, and only after a write-enable instruction has armed the block. The block keeps the write-enable latch itself. It reports that latch and the back end's busy input in the status byte.

Top module: `sflash_cmd_frontend`

## Requirements
- R1: Every instruction starts afresh at the falling edge of chip-select. Bits are taken from `si` on the rising `sck` edge, most significant bit first, and a partial opcode from an earlier selection has no effect on the next one.
- R2: Opcodes 03h, 0Bh, 20h, 52h, D8h, 02h, ADh, 90h and ABh take three address bytes, high byte first, which appear on `cmd_addr`. 0Bh is followed by one dummy byte. `go_read` pulses after the last address byte of 03h, and `go_fread` pulses after the dummy byte of 0Bh.
- R3: Program (02h), word program (ADh), erase (20h, 52h, D8h, 60h, C7h) and status write (01h) produce a strobe only when the write-enable latch is set. 01h is also accepted after 50h. `erase_size` encodes 0 for 20h, 1 for 52h, 2 for D8h and 3 for 60h/C7h.
- R4: A write-class instruction executes when chip-select rises after a complete byte. A rise in the middle of a byte discards the instruction with no strobe, and the write-enable latch is left unchanged.
- R5: 06h sets the write-enable latch. 04h clears it, and so does every executed write-class instruction. The status byte carries `busy` in bit 0 and the latch in bit 1, with all other bits zero.
- R6: 05h returns the status byte again and again while chip-select stays low.
- R7: During 03h and 0Bh the output byte is `mem_rdata` for the current `cmd_addr`, and the address rises by one per byte. Bits change on the falling `sck` edge, most significant bit first.
- R8: 90h/ABh alternate the manufacturer and device bytes, starting with the device byte when address bit 0 is 1. 9Fh returns manufacturer, memory type and device bytes in a repeating cycle.
- R9: `slow_read` is high during an accepted 03h instruction and low during every other instruction.
- R10: An opcode that completes while `busy` is high is ignored: no output, no strobe, no change to the latch. The only exception is 05h.
- R11: `so` is 0 whenever chip-select is high.
- R12: `wr_data` carries the data byte of 02h and 01h in bits 7:0. For ADh it carries the first data byte in bits 15:8 and the second in bits 7:0. Bytes beyond those are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, at least four times the serial clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock, synchronous to `clk` |
| si | input | 1 | Serial data in |
| busy | input | 1 | Back end is erasing or programming |
| mem_rdata | input | 8 | Array byte at `cmd_addr` |
| so | output | 1 | Serial data out |
| slow_read | output | 1 | A 03h read is in progress |
| cmd_addr | output | 24 | Instruction address, read pointer during reads |
| wr_data | output | 16 | Write data for program and status write |
| erase_size | output | 2 | Erase granularity, valid with `go_erase` |
| go_read | output | 1 | Read strobe |
| go_fread | output | 1 | Fast-read strobe |
| go_erase | output | 1 | Erase strobe |
| go_prog | output | 1 | Byte-program strobe |
| go_aai | output | 1 | Word-program start strobe |
| go_wrsr | output | 1 | Status-write strobe |

## Verification
The assertions take three things about the inputs for granted. Chip-select stays high for at least two clock cycles after it rises. It never changes in the same cycle as a serial-clock edge. Each serial-clock phase lasts at least two clock cycles, so that `mem_rdata` has settled before a byte is loaded. The bench drives every line on the falling clock edge with two-cycle clock phases. It raises chip-select only half a serial period after the last falling edge and holds it high for four cycles. The bench never changes `busy` inside a selection.

// File: rtl/sflash_cmd_frontend.sv
module sflash_cmd_frontend #(
  parameter logic [7:0] MFR_ID   = 8'h5E,
  parameter logic [7:0] MEM_TYPE = 8'h25,
  parameter logic [7:0] DEV_ID   = 8'h4A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        sck,
  input  logic        si,
  input  logic        busy,
  input  logic [7:0]  mem_rdata,
  output logic        so,
  output logic        slow_read,
  output logic [23:0] cmd_addr,
  output logic [15:0] wr_data,
  output logic [1:0]  erase_size,
  output logic        go_read,
  output logic        go_fread,
  output logic        go_erase,
  output logic        go_prog,
  output logic        go_aai,
  output logic        go_wrsr
);
  logic       sck_q, cs_q, ign, wel, wsr_en, so_q;
  logic [2:0] bitcnt, nbytes;
  logic [1:0] jcnt;
  logic [7:0] op, shin, shout, src;

  function automatic logic [2:0] hdr_len(input logic [7:0] o);
    case (o)
      8'h03, 8'h90, 8'hAB: return 3'd4;
      8'h0B:               return 3'd5;
      8'h05, 8'h9F:        return 3'd1;
      default:             return 3'd0;
    endcase
  endfunction

  function automatic logic has_addr(input logic [7:0] o);
    case (o)
      8'h03, 8'h0B, 8'h20, 8'h52, 8'hD8, 8'h02, 8'hAD, 8'h90, 8'hAB: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  wire       rise     = !cs_n && sck && !sck_q;
  wire       fall     = !cs_n && !sck && sck_q;
  wire       cs_up    = cs_n && !cs_q;
  wire [7:0] inb      = {shin[6:0], si};
  wire       have_op  = nbytes != 3'd0;
  wire       rd_phase = have_op && !ign && hdr_len(op) != 3'd0 && nbytes >= hdr_len(op);
  wire [7:0] stat     = {6'b0, wel, busy};
  wire       ptr_inc  = op == 8'h03 || op == 8'h0B || op == 8'h90 || op == 8'hAB;

  always_comb begin
    case (op)
      8'h03, 8'h0B: src = mem_rdata;
      8'h05:        src = stat;
      8'h9F:        src = (jcnt == 2'd0) ? MFR_ID : (jcnt == 2'd1) ? MEM_TYPE : DEV_ID;
      default:      src = cmd_addr[0] ? DEV_ID : MFR_ID;
    endcase
  end

  assign so        = !cs_n && so_q;
  assign slow_read = !cs_n && have_op && !ign && op == 8'h03;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b1; ign <= 1'b0; wel <= 1'b0; wsr_en <= 1'b0;
      so_q <= 1'b0; bitcnt <= 3'd0; nbytes <= 3'd0; jcnt <= 2'd0;
      op <= 8'h00; shin <= 8'h00; shout <= 8'h00;
      cmd_addr <= 24'h0; wr_data <= 16'h0; erase_size <= 2'd0;
      go_read <= 1'b0; go_fread <= 1'b0; go_erase <= 1'b0;
      go_prog <= 1'b0; go_aai <= 1'b0; go_wrsr <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      go_read <= 1'b0; go_fread <= 1'b0; go_erase <= 1'b0;
      go_prog <= 1'b0; go_aai <= 1'b0; go_wrsr <= 1'b0;
      if (cs_n) begin
        if (cs_up && bitcnt == 3'd0 && have_op && !ign) begin
          case (op)
            8'h06: wel <= 1'b1;
            8'h04: begin wel <= 1'b0; wsr_en <= 1'b0; end
            8'h50: wsr_en <= 1'b1;
            8'h02: if (nbytes >= 3'd5 && wel) begin go_prog <= 1'b1; wel <= 1'b0; wsr_en <= 1'b0; end
            8'hAD: if (nbytes >= 3'd6 && wel) begin go_aai <= 1'b1; wel <= 1'b0; wsr_en <= 1'b0; end
            8'h20: if (nbytes >= 3'd4 && wel) begin go_erase <= 1'b1; erase_size <= 2'd0; wel <= 1'b0; wsr_en <= 1'b0; end
            8'h52: if (nbytes >= 3'd4 && wel) begin go_erase <= 1'b1; erase_size <= 2'd1; wel <= 1'b0; wsr_en <= 1'b0; end
            8'hD8: if (nbytes >= 3'd4 && wel) begin go_erase <= 1'b1; erase_size <= 2'd2; wel <= 1'b0; wsr_en <= 1'b0; end
            8'h60, 8'hC7: if (wel) begin go_erase <= 1'b1; erase_size <= 2'd3; wel <= 1'b0; wsr_en <= 1'b0; end
            8'h01: if (nbytes >= 3'd2 && (wel || wsr_en)) begin go_wrsr <= 1'b1; wel <= 1'b0; wsr_en <= 1'b0; end
            default: ;
          endcase
        end
        bitcnt <= 3'd0; nbytes <= 3'd0; ign <= 1'b0; so_q <= 1'b0; jcnt <= 2'd0;
      end else begin
        if (rise) begin
          shin   <= inb;
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            if (nbytes != 3'd7) nbytes <= nbytes + 3'd1;
            if (nbytes == 3'd0) begin
              op  <= inb;
              ign <= busy && inb != 8'h05;
            end else if (!ign) begin
              if (nbytes <= 3'd3 && has_addr(op)) cmd_addr <= {cmd_addr[15:0], inb};
              if (nbytes == 3'd3 && op == 8'h03) go_read <= 1'b1;
              if (nbytes == 3'd4 && op == 8'h0B) go_fread <= 1'b1;
              if ((nbytes == 3'd1 && op == 8'h01) || (nbytes == 3'd4 && op == 8'h02))
                wr_data <= {8'h00, inb};
              if (nbytes == 3'd4 && op == 8'hAD) wr_data[15:8] <= inb;
              if (nbytes == 3'd5 && op == 8'hAD) wr_data[7:0] <= inb;
            end
          end
        end
        if (fall && rd_phase) begin
          if (bitcnt == 3'd0) begin
            so_q  <= src[7];
            shout <= {src[6:0], 1'b0};
            if (ptr_inc) cmd_addr <= cmd_addr + 24'd1;
            if (op == 8'h9F) jcnt <= (jcnt == 2'd2) ? 2'd0 : jcnt + 2'd1;
          end else begin
            so_q  <= shout[7];
            shout <= {shout[6:0], 1'b0};
          end
        end
      end
    end
  end

  // R3
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_prog || go_aai || go_erase) |-> $past(wel));

  // R3
  wrsr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_wrsr |-> $past(wel || wsr_en));

  // R5
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_prog || go_aai || go_erase || go_wrsr) |-> !wel);

  // R4
  exec_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_prog || go_aai || go_erase || go_wrsr) |-> cs_n);

  // R2
  read_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_read || go_fread) |-> !cs_n);

  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_read, go_fread, go_erase, go_prog, go_aai, go_wrsr}));
endmodule

// File: tb/sflash_cmd_frontend_bench.sv
module sflash_cmd_frontend_bench;
  localparam int HP = 2;
  localparam logic [7:0] MFR = 8'h5E, TYP = 8'h25, DEV = 8'h4A;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, busy = 1'b0;
  logic [7:0] mem_rdata;
  logic so, slow_read, go_read, go_fread, go_erase, go_prog, go_aai, go_wrsr;
  logic [23:0] cmd_addr;
  logic [15:0] wr_data;
  logic [1:0] erase_size;

  always #5 clk = ~clk;

  function automatic logic [7:0] memf(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction
  assign mem_rdata = memf(cmd_addr);

  sflash_cmd_frontend u_sflash_cmd_frontend (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .busy(busy),
    .mem_rdata(mem_rdata), .so(so), .slow_read(slow_read), .cmd_addr(cmd_addr),
    .wr_data(wr_data), .erase_size(erase_size), .go_read(go_read),
    .go_fread(go_fread), .go_erase(go_erase), .go_prog(go_prog),
    .go_aai(go_aai), .go_wrsr(go_wrsr));

  int n_chk = 0, n_fail = 0, idle_err = 0;
  int c_read = 0, c_fread = 0, c_erase = 0, c_prog = 0, c_aai = 0, c_wrsr = 0;
  logic [23:0] cap_addr;
  logic [15:0] cap_data;
  logic [1:0]  cap_size;
  logic slow_seen = 1'b0, done = 1'b0, wel_m = 1'b0;
  logic [7:0] rxq[$];

  always @(negedge clk) begin
    if (cs_n && so !== 1'b0) idle_err++;
    if (slow_read) slow_seen = 1'b1;
    if (go_read)  c_read++;
    if (go_fread) c_fread++;
    if (go_erase) begin c_erase++; cap_size = erase_size; cap_addr = cmd_addr; end
    if (go_prog)  begin c_prog++; cap_addr = cmd_addr; cap_data = wr_data; end
    if (go_aai)   begin c_aai++;  cap_addr = cmd_addr; cap_data = wr_data; end
    if (go_wrsr)  begin c_wrsr++; cap_data = wr_data; end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bitx(input logic b, output logic r);
    si = b; tick(HP); r = so; sck = 1'b1; tick(HP); sck = 1'b0;
  endtask

  // n header bytes from hdr (left-justified), nread zero bytes captured, extra partial bits
  task automatic xact(input int n, input logic [47:0] hdr, input int nread, input int extra);
    logic r;
    logic [7:0] rb, tb;
    rxq.delete();
    slow_seen = 1'b0;
    cs_n = 1'b0; tick(2);
    for (int k = 0; k < n + nread; k++) begin
      tb = (k < n) ? hdr[47-8*k -: 8] : 8'h00;
      for (int i = 7; i >= 0; i--) begin bitx(tb[i], r); rb[i] = r; end
      if (k >= n) rxq.push_back(rb);
    end
    for (int i = 0; i < extra; i++) bitx(1'b1, r);
    tick(HP); cs_n = 1'b1; tick(4);
  endtask

  task automatic status_chk(input string req);
    xact(1, {8'h05, 40'h0}, 2, 0);
    chk(req, rxq[0], {6'b0, wel_m, busy});
    chk(req, rxq[1], {6'b0, wel_m, busy});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] eops[5] = '{8'h52, 8'hD8, 8'h20, 8'hC7, 8'h60};
    logic [1:0] esz[5]  = '{2'd1, 2'd2, 2'd0, 2'd3, 2'd3};
    tick(4); rst_n = 1'b1; tick(2);
    chk("R11 reset so", so, 0);
    chk("R9 reset slow_read", slow_read, 0);
    chk("R4 reset strobes", {go_read, go_fread, go_erase, go_prog, go_aai, go_wrsr}, 0);

    status_chk("R6 status repeat");

    xact(5, {8'h02, 24'h123456, 8'hA5, 8'h00}, 0, 0);
    chk("R3 program without enable", c_prog, 0);

    xact(1, {8'h06, 40'h0}, 0, 0); wel_m = 1'b1;
    status_chk("R5 latch set");

    xact(5, {8'h02, 24'h123456, 8'hA5, 8'h00}, 0, 0); wel_m = 1'b0;
    chk("R3 program strobe", c_prog, 1);
    chk("R2 program addr", cap_addr, 24'h123456);
    chk("R12 program data", cap_data, 16'h00A5);
    status_chk("R5 latch cleared by program");

    xact(1, {8'h06, 40'h0}, 0, 0); wel_m = 1'b1;
    xact(3, {8'h20, 16'hABCD, 24'h0}, 0, 4);
    chk("R4 aborted erase", c_erase, 0);
    status_chk("R4 latch kept after abort");

    for (int i = 0; i < 5; i++) begin
      xact(1, {8'h06, 40'h0}, 0, 0);
      xact((esz[i] == 2'd3) ? 1 : 4, {eops[i], 24'h0A0B00 + 24'(i), 16'h0}, 0, 0);
      chk("R3 erase strobe", c_erase, i + 1);
      chk("R3 erase size", cap_size, esz[i]);
      if (esz[i] != 2'd3) chk("R2 erase addr", cap_addr, 24'h0A0B00 + 24'(i));
    end
    wel_m = 1'b0;
    status_chk("R5 latch cleared by erase");

    xact(1, {8'h06, 40'h0}, 0, 0);
    xact(1, {8'h04, 40'h0}, 0, 0); wel_m = 1'b0;
    status_chk("R5 latch cleared by disable");

    xact(2, {8'h01, 8'h77, 32'h0}, 0, 0);
    chk("R3 status write without enable", c_wrsr, 0);
    xact(1, {8'h50, 40'h0}, 0, 0);
    xact(2, {8'h01, 8'h55, 32'h0}, 0, 0);
    chk("R3 status write after 50h", c_wrsr, 1);
    chk("R12 status write data", cap_data, 16'h0055);
    xact(1, {8'h06, 40'h0}, 0, 0);
    xact(3, {8'h01, 8'h66, 8'h99, 24'h0}, 0, 0);
    chk("R12 extra byte ignored", cap_data, 16'h0066);

    xact(1, {8'h06, 40'h0}, 0, 0);
    xact(6, {8'hAD, 24'h000100, 8'hAA, 8'hBB}, 0, 0);
    chk("R3 word program strobe", c_aai, 1);
    chk("R12 word program data", cap_data, 16'hAABB);
    chk("R2 word program addr", cap_addr, 24'h000100);
    status_chk("R5 latch cleared by word program");

    xact(4, {8'h03, 24'h00FFFE, 16'h0}, 4, 0);
    for (int i = 0; i < 4; i++) chk("R7 read byte", rxq[i], memf(24'h00FFFE + 24'(i)));
    chk("R2 read strobe", c_read, 1);
    chk("R9 slow flag on 03h", slow_seen, 1);

    xact(5, {8'h0B, 24'h123400, 8'h00, 8'h0}, 3, 0);
    for (int i = 0; i < 3; i++) chk("R2 fast read byte", rxq[i], memf(24'h123400 + 24'(i)));
    chk("R2 fast read strobe", c_fread, 1);
    chk("R9 slow flag off on 0Bh", slow_seen, 0);

    xact(4, {8'h90, 24'h000000, 16'h0}, 3, 0);
    chk("R8 id even 0", rxq[0], MFR);
    chk("R8 id even 1", rxq[1], DEV);
    chk("R8 id even 2", rxq[2], MFR);
    xact(4, {8'hAB, 24'h000001, 16'h0}, 2, 0);
    chk("R8 id odd 0", rxq[0], DEV);
    chk("R8 id odd 1", rxq[1], MFR);
    xact(1, {8'h9F, 40'h0}, 4, 0);
    chk("R8 jedec 0", rxq[0], MFR);
    chk("R8 jedec 1", rxq[1], TYP);
    chk("R8 jedec 2", rxq[2], DEV);
    chk("R8 jedec wrap", rxq[3], MFR);

    busy = 1'b1; tick(2);
    status_chk("R5 busy bit");
    xact(1, {8'h06, 40'h0}, 0, 0);
    xact(4, {8'h03, 24'h000010, 16'h0}, 2, 0);
    chk("R10 busy read silent", {rxq[0], rxq[1]}, 16'h0000);
    chk("R10 busy read no strobe", c_read, 1);
    chk("R10 busy read no slow flag", slow_seen, 0);
    busy = 1'b0; tick(2);
    status_chk("R10 enable ignored while busy");

    xact(0, 48'h0, 0, 3);
    xact(1, {8'h06, 40'h0}, 0, 0); wel_m = 1'b1;
    status_chk("R1 restart after partial opcode");
    xact(1, {8'h04, 40'h0}, 0, 0); wel_m = 1'b0;

    chk("R11 so idle while deselected", idle_err, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule